// File: doc/BRIEF.md
# Row-Closure Decision Unit for a DRAM Scheduler

Each time a DRAM scheduler commits an access to a bank, this unit decides whether that access should also close the row with an auto-precharge. A 2-bit page-policy input selects how aggressive closure is. Under the always-open policy a row stays open until it hits an access cap. Under the always-close policy every access closes its row. The two adaptive policies look ahead through the pending queue. The lookahead uses the read queue for a read and the write queue for a write, and it skips the head slot because that slot holds the request being decided.

The unit keeps its own per-bank table. For each bank it holds whether a row is open, which row that is, how many accesses have gone to it, and how many bytes they moved. It compares the incoming row against this table to tell a row hit from a fresh activate. When the row is closed, it reports when the precharge completes: the later of the bank-free time and the row-active-minimum time, plus the precharge time. All decisions are registered and appear one cycle after the request strobe, together with a one-cycle done pulse.

Top module: `apd_top`

## Requirements
- R1: `decDone` is high for exactly the one cycle after each cycle in which `reqStrobe` is high, and is low otherwise.
- R2: With `pagePolicy` = 2 (close), every access reports `decPrecharge` = 1.
- R3: With `pagePolicy` = 0 (open), `decPrecharge` is 1 only when the access count reaches `MAX_ACC`.
- R4: An access to a bank with no open row, or with a different open row, reports `decRowHit` = 0, `decRowCount` = 1 and `decByteCount` = `BURST_BYTES`. An access to the open row reports `decRowHit` = 1 and increments both counts, by 1 and by `BURST_BYTES`.
- R5: Under every policy, an access whose count reaches `MAX_ACC` (default 4) reports `decPrecharge` = 1.
- R6: With `pagePolicy` = 1 (open-adaptive), the row is closed when there is no queued hit and at least one queued conflict. If a hit is queued, or if neither a hit nor a conflict is queued, the row stays open.
- R7: With `pagePolicy` = 3 (close-adaptive), the row is closed exactly when no queued hit exists.
- R8: A queued entry is a hit when its rank, bank and row all equal the request's. It is a conflict when rank and bank match but the row differs. An entry with a different rank is neither.
- R9: Queue slot 0 (the head) and entries whose valid bit is 0 take no part in hit or conflict detection.
- R10: `reqIsRead` = 1 scans the read queue and `reqIsRead` = 0 scans the write queue. The other queue has no effect.
- R11: When `decPrecharge` = 1, `decPreDoneAt` = max(`bankFreeAt`, `rasDoneAt`) + `T_RP`. Otherwise it is 0.
- R12: After a closing access, the bank holds no open row, so the next access to the same row is a miss (R4).
- R13: Reset clears `decDone` and `decPrecharge` and leaves every bank with no open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStrobe | input | 1 | Request valid for one cycle |
| pagePolicy | input | 2 | 0 open, 1 open-adaptive, 2 close, 3 close-adaptive |
| reqIsRead | input | 1 | 1 read (read queue scanned), 0 write |
| reqRank | input | RANK_W | Request rank |
| reqBank | input | BANK_W | Request bank |
| reqRow | input | ROW_W | Request row |
| bankFreeAt | input | TIME_W | Time the bank becomes free |
| rasDoneAt | input | TIME_W | Time the row-active minimum expires |
| rdQValid | input | QUEUE_DEPTH | Read queue valid bits |
| rdQRank | input | QUEUE_DEPTH x RANK_W | Read queue ranks |
| rdQBank | input | QUEUE_DEPTH x BANK_W | Read queue banks |
| rdQRow | input | QUEUE_DEPTH x ROW_W | Read queue rows |
| wrQValid | input | QUEUE_DEPTH | Write queue valid bits |
| wrQRank | input | QUEUE_DEPTH x RANK_W | Write queue ranks |
| wrQBank | input | QUEUE_DEPTH x BANK_W | Write queue banks |
| wrQRow | input | QUEUE_DEPTH x ROW_W | Write queue rows |
| decDone | output | 1 | Decision valid pulse |
| decPrecharge | output | 1 | Access carries auto-precharge |
| decPreDoneAt | output | TIME_W | Precharge completion time |
| decRowHit | output | 1 | Access hit the open row |
| decRowCount | output | CNT_W | Accesses to the row including this one |
| decByteCount | output | BYTE_W | Bytes moved on the row including this one |

## Verification
The assertions assume that request fields, both queues and both time inputs are stable while `reqStrobe` is high. They also assume the time inputs are small enough that adding `T_RP` cannot wrap. The policy checks look back one cycle to the policy that went with the strobe, so the policy must be presented in the same cycle as its strobe. The bench drives every input on the falling edge, keeps each strobe to a single cycle or to back-to-back single requests, and uses times far below the wrap point. It clears both queues before each request so that no entries carry over from one request to the next.

// File: rtl/apd_pkg.sv
package apd_pkg;

  typedef enum logic [1:0] {
    POL_OPEN        = 2'd0,
    POL_OPEN_ADAPT  = 2'd1,
    POL_CLOSE       = 2'd2,
    POL_CLOSE_ADAPT = 2'd3
  } pagePolicy_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic update;    // commit the access to the bank table and outputs
    logic closeRow;  // the access carries auto-precharge
  } apdCtrl_t;

endpackage

// File: rtl/apd_queue_scan.sv
module apd_queue_scan #(
  parameter int QUEUE_DEPTH = 16,
  parameter int RANK_W      = 1,
  parameter int BANK_W      = 3,
  parameter int ROW_W       = 14
) (
  input  logic [QUEUE_DEPTH-1:0]             qValid,
  input  logic [QUEUE_DEPTH-1:0][RANK_W-1:0] qRank,
  input  logic [QUEUE_DEPTH-1:0][BANK_W-1:0] qBank,
  input  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]  qRow,
  input  logic [RANK_W-1:0]                  curRank,
  input  logic [BANK_W-1:0]                  curBank,
  input  logic [ROW_W-1:0]                   curRow,
  output logic                               anyHit,
  output logic                               anyConflict
);

  logic [QUEUE_DEPTH-1:0] hitVec;
  logic [QUEUE_DEPTH-1:0] conflictVec;

  // slot 0 is the request under decision and never counts
  assign hitVec[0]      = 1'b0;
  assign conflictVec[0] = 1'b0;

  for (genvar i = 1; i < QUEUE_DEPTH; i++) begin : g_slot
    logic sameBank;
    assign sameBank       = qValid[i] && (qRank[i] == curRank) && (qBank[i] == curBank);
    assign hitVec[i]      = sameBank && (qRow[i] == curRow);
    assign conflictVec[i] = sameBank && (qRow[i] != curRow);
  end

  assign anyHit      = |hitVec;
  assign anyConflict = |conflictVec;

endmodule

// File: rtl/apd_datapath.sv
module apd_datapath
  import apd_pkg::*;
#(
  parameter int RANK_W      = 1,
  parameter int BANK_W      = 3,
  parameter int ROW_W       = 14,
  parameter int TIME_W      = 32,
  parameter int QUEUE_DEPTH = 16,
  parameter int MAX_ACC     = 4,
  parameter int BURST_BYTES = 64,
  parameter int T_RP        = 15,
  parameter int CNT_W       = 3,
  parameter int BYTE_W      = 9
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  apdCtrl_t                            ctrl,
  input  logic                                reqIsRead,
  input  logic [RANK_W-1:0]                   reqRank,
  input  logic [BANK_W-1:0]                   reqBank,
  input  logic [ROW_W-1:0]                    reqRow,
  input  logic [TIME_W-1:0]                   bankFreeAt,
  input  logic [TIME_W-1:0]                   rasDoneAt,
  input  logic [QUEUE_DEPTH-1:0]              rdQValid,
  input  logic [QUEUE_DEPTH-1:0][RANK_W-1:0]  rdQRank,
  input  logic [QUEUE_DEPTH-1:0][BANK_W-1:0]  rdQBank,
  input  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]   rdQRow,
  input  logic [QUEUE_DEPTH-1:0]              wrQValid,
  input  logic [QUEUE_DEPTH-1:0][RANK_W-1:0]  wrQRank,
  input  logic [QUEUE_DEPTH-1:0][BANK_W-1:0]  wrQBank,
  input  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]   wrQRow,
  output logic                                capReached,
  output logic                                moreHits,
  output logic                                anyConflict,
  output logic                                decPrecharge,
  output logic [TIME_W-1:0]                   decPreDoneAt,
  output logic                                decRowHit,
  output logic [CNT_W-1:0]                    decRowCount,
  output logic [BYTE_W-1:0]                   decByteCount
);

  localparam int BIDX_W    = RANK_W + BANK_W;
  localparam int NUM_BANKS = 1 << BIDX_W;

  // per-bank row table
  logic [NUM_BANKS-1:0]             openValid;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  openRow;
  logic [NUM_BANKS-1:0][CNT_W-1:0]  rowCnt;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] byteCnt;

  logic [BIDX_W-1:0] bankIdx;
  logic              rowHit;
  logic [CNT_W-1:0]  nextCnt;
  logic [BYTE_W-1:0] nextBytes;
  logic [TIME_W-1:0] laterTime;

  assign bankIdx = {reqRank, reqBank};
  assign rowHit  = openValid[bankIdx] && (openRow[bankIdx] == reqRow);

  always_comb begin
    if (rowHit) begin
      nextCnt   = rowCnt[bankIdx] + CNT_W'(1);
      nextBytes = byteCnt[bankIdx] + BYTE_W'(BURST_BYTES);
    end else begin
      nextCnt   = CNT_W'(1);
      nextBytes = BYTE_W'(BURST_BYTES);
    end
  end

  assign capReached = (nextCnt == CNT_W'(MAX_ACC));
  assign laterTime  = (bankFreeAt > rasDoneAt) ? bankFreeAt : rasDoneAt;

  // queue selection by direction, then lookahead
  logic [QUEUE_DEPTH-1:0]             selValid;
  logic [QUEUE_DEPTH-1:0][RANK_W-1:0] selRank;
  logic [QUEUE_DEPTH-1:0][BANK_W-1:0] selBank;
  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]  selRow;

  always_comb begin
    if (reqIsRead) begin
      selValid = rdQValid;
      selRank  = rdQRank;
      selBank  = rdQBank;
      selRow   = rdQRow;
    end else begin
      selValid = wrQValid;
      selRank  = wrQRank;
      selBank  = wrQBank;
      selRow   = wrQRow;
    end
  end

  apd_queue_scan #(
    .QUEUE_DEPTH(QUEUE_DEPTH),
    .RANK_W     (RANK_W),
    .BANK_W     (BANK_W),
    .ROW_W      (ROW_W)
  ) u_scan (
    .qValid     (selValid),
    .qRank      (selRank),
    .qBank      (selBank),
    .qRow       (selRow),
    .curRank    (reqRank),
    .curBank    (reqBank),
    .curRow     (reqRow),
    .anyHit     (moreHits),
    .anyConflict(anyConflict)
  );

  // bank table update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openValid <= '0;
      openRow   <= '0;
      rowCnt    <= '0;
      byteCnt   <= '0;
    end else if (ctrl.update) begin
      openValid[bankIdx] <= !ctrl.closeRow;
      openRow[bankIdx]   <= reqRow;
      rowCnt[bankIdx]    <= nextCnt;
      byteCnt[bankIdx]   <= nextBytes;
    end
  end

  // registered decision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decPrecharge <= 1'b0;
      decPreDoneAt <= '0;
      decRowHit    <= 1'b0;
      decRowCount  <= '0;
      decByteCount <= '0;
    end else if (ctrl.update) begin
      decPrecharge <= ctrl.closeRow;
      decPreDoneAt <= ctrl.closeRow ? (laterTime + TIME_W'(T_RP)) : '0;
      decRowHit    <= rowHit;
      decRowCount  <= nextCnt;
      decByteCount <= nextBytes;
    end
  end

  // R4: byte count tracks access count on the row
  assert_bytes_track_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.update |=> (32'(decByteCount) == 32'(decRowCount) * BURST_BYTES));

  // R5: count never leaves 1..MAX_ACC after an update
  assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.update |=> (decRowCount >= CNT_W'(1) && 32'(decRowCount) <= MAX_ACC));

endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStrobe,
  input  logic [1:0]  pagePolicy,
  input  logic        capReached,
  input  logic        moreHits,
  input  logic        anyConflict,
  output apdCtrl_t    ctrl,
  output logic        decDone
);

  pagePolicy_e policy;
  logic        closeWanted;

  assign policy = pagePolicy_e'(pagePolicy);

  always_comb begin
    unique case (policy)
      POL_OPEN:        closeWanted = capReached;
      POL_OPEN_ADAPT:  closeWanted = capReached || (!moreHits && anyConflict);
      POL_CLOSE:       closeWanted = 1'b1;
      POL_CLOSE_ADAPT: closeWanted = capReached || !moreHits;
      default:         closeWanted = 1'b1;
    endcase
  end

  assign ctrl.update   = reqStrobe;
  assign ctrl.closeRow = closeWanted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decDone <= 1'b0;
    else       decDone <= reqStrobe;
  end

  // R1: done follows each strobe by one cycle
  assert_done_after_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |=> decDone);

  // R1: no done without a strobe
  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqStrobe |=> !decDone);

endmodule

// File: rtl/apd_top.sv
module apd_top
  import apd_pkg::*;
#(
  parameter int RANK_W      = 1,
  parameter int BANK_W      = 3,
  parameter int ROW_W       = 14,
  parameter int TIME_W      = 32,
  parameter int QUEUE_DEPTH = 16,
  parameter int MAX_ACC     = 4,
  parameter int BURST_BYTES = 64,
  parameter int T_RP        = 15,
  localparam int CNT_W      = $clog2(MAX_ACC + 1),
  localparam int BYTE_W     = $clog2(MAX_ACC * BURST_BYTES + 1)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqStrobe,
  input  logic [1:0]                          pagePolicy,
  input  logic                                reqIsRead,
  input  logic [RANK_W-1:0]                   reqRank,
  input  logic [BANK_W-1:0]                   reqBank,
  input  logic [ROW_W-1:0]                    reqRow,
  input  logic [TIME_W-1:0]                   bankFreeAt,
  input  logic [TIME_W-1:0]                   rasDoneAt,
  input  logic [QUEUE_DEPTH-1:0]              rdQValid,
  input  logic [QUEUE_DEPTH-1:0][RANK_W-1:0]  rdQRank,
  input  logic [QUEUE_DEPTH-1:0][BANK_W-1:0]  rdQBank,
  input  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]   rdQRow,
  input  logic [QUEUE_DEPTH-1:0]              wrQValid,
  input  logic [QUEUE_DEPTH-1:0][RANK_W-1:0]  wrQRank,
  input  logic [QUEUE_DEPTH-1:0][BANK_W-1:0]  wrQBank,
  input  logic [QUEUE_DEPTH-1:0][ROW_W-1:0]   wrQRow,
  output logic                                decDone,
  output logic                                decPrecharge,
  output logic [TIME_W-1:0]                   decPreDoneAt,
  output logic                                decRowHit,
  output logic [CNT_W-1:0]                    decRowCount,
  output logic [BYTE_W-1:0]                   decByteCount
);

  apdCtrl_t ctrl;
  logic     capReached;
  logic     moreHits;
  logic     anyConflict;

  apd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqStrobe  (reqStrobe),
    .pagePolicy (pagePolicy),
    .capReached (capReached),
    .moreHits   (moreHits),
    .anyConflict(anyConflict),
    .ctrl       (ctrl),
    .decDone    (decDone)
  );

  apd_datapath #(
    .RANK_W     (RANK_W),
    .BANK_W     (BANK_W),
    .ROW_W      (ROW_W),
    .TIME_W     (TIME_W),
    .QUEUE_DEPTH(QUEUE_DEPTH),
    .MAX_ACC    (MAX_ACC),
    .BURST_BYTES(BURST_BYTES),
    .T_RP       (T_RP),
    .CNT_W      (CNT_W),
    .BYTE_W     (BYTE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqIsRead   (reqIsRead),
    .reqRank     (reqRank),
    .reqBank     (reqBank),
    .reqRow      (reqRow),
    .bankFreeAt  (bankFreeAt),
    .rasDoneAt   (rasDoneAt),
    .rdQValid    (rdQValid),
    .rdQRank     (rdQRank),
    .rdQBank     (rdQBank),
    .rdQRow      (rdQRow),
    .wrQValid    (wrQValid),
    .wrQRank     (wrQRank),
    .wrQBank     (wrQBank),
    .wrQRow      (wrQRow),
    .capReached  (capReached),
    .moreHits    (moreHits),
    .anyConflict (anyConflict),
    .decPrecharge(decPrecharge),
    .decPreDoneAt(decPreDoneAt),
    .decRowHit   (decRowHit),
    .decRowCount (decRowCount),
    .decByteCount(decByteCount)
  );

  // R2: the close policy always precharges
  assert_close_always_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && pagePolicy == POL_CLOSE) |=> decPrecharge);

  // R3: the open policy closes only at the access cap
  assert_open_only_at_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && pagePolicy == POL_OPEN) |=> (decPrecharge == (32'(decRowCount) == MAX_ACC)));

  // R11: completion time of the precharge
  assert_pre_time_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |=> (decPrecharge
      ? (decPreDoneAt == (($past(bankFreeAt) > $past(rasDoneAt) ? $past(bankFreeAt) : $past(rasDoneAt))
                          + TIME_W'(T_RP)))
      : (decPreDoneAt == '0)));

endmodule

// File: tb/sim_apd_top.sv
module sim_apd_top;

  localparam int QD = 16;

  typedef struct packed {
    logic        v;
    logic [3:0]  idx;
    logic        rk;
    logic [2:0]  bk;
    logic [13:0] row;
  } qent_t;

  typedef struct packed {
    logic [1:0]  pol;
    logic        rd;
    logic        toWr;     // entries go to the write queue
    logic        rk;
    logic [2:0]  bk;
    logic [13:0] row;
    logic [31:0] freeAt;
    logic [31:0] rasAt;
    qent_t       e0;
    qent_t       e1;
    logic        expPre;
    logic        expHit;
    logic [2:0]  expCnt;
    logic [31:0] expDone;
  } vec_t;

  localparam qent_t NOE = '{1'b0, 4'd0, 1'b0, 3'd0, 14'd0};
  localparam int NV = 20;

  // policy codes: 0 open, 1 open-adaptive, 2 close, 3 close-adaptive
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 14'd10, 32'd100, 32'd120, NOE, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 14'd10, 32'd100, 32'd120, NOE, NOE, 1'b0, 1'b1, 3'd2, 32'd0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 14'd10, 32'd100, 32'd120, NOE, NOE, 1'b0, 1'b1, 3'd3, 32'd0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 14'd10, 32'd100, 32'd120, NOE, NOE, 1'b1, 1'b1, 3'd4, 32'd135},
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 14'd10, 32'd100, 32'd120, NOE, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 3'd1, 14'd5,  32'd200, 32'd150, NOE, NOE, 1'b1, 1'b0, 3'd1, 32'd215},
    '{2'd1, 1'b1, 1'b0, 1'b0, 3'd2, 14'd7,  32'd0,   32'd0,
      '{1'b1, 4'd1, 1'b0, 3'd2, 14'd7}, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 3'd2, 14'd7,  32'd300, 32'd310,
      '{1'b1, 4'd2, 1'b0, 3'd2, 14'd9}, NOE, 1'b1, 1'b1, 3'd2, 32'd325},
    '{2'd1, 1'b1, 1'b0, 1'b0, 3'd3, 14'd1,  32'd0,   32'd0,
      '{1'b1, 4'd3, 1'b0, 3'd3, 14'd1}, '{1'b1, 4'd4, 1'b0, 3'd3, 14'd2}, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 3'd3, 14'd1,  32'd0,   32'd0,   NOE, NOE, 1'b0, 1'b1, 3'd2, 32'd0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 3'd4, 14'd3,  32'd10,  32'd10,  NOE, NOE, 1'b1, 1'b0, 3'd1, 32'd25},
    '{2'd3, 1'b1, 1'b0, 1'b0, 3'd5, 14'd3,  32'd0,   32'd0,
      '{1'b1, 4'd5, 1'b0, 3'd5, 14'd3}, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 3'd5, 14'd3,  32'd50,  32'd40,
      '{1'b1, 4'd0, 1'b0, 3'd5, 14'd3}, NOE, 1'b1, 1'b1, 3'd2, 32'd65},
    '{2'd3, 1'b0, 1'b0, 1'b0, 3'd6, 14'd8,  32'd0,   32'd0,
      '{1'b1, 4'd1, 1'b0, 3'd6, 14'd8}, NOE, 1'b1, 1'b0, 3'd1, 32'd15},
    '{2'd3, 1'b0, 1'b1, 1'b0, 3'd6, 14'd8,  32'd0,   32'd0,
      '{1'b1, 4'd1, 1'b0, 3'd6, 14'd8}, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd3, 1'b0, 1'b1, 1'b0, 3'd6, 14'd8,  32'd70,  32'd80,
      '{1'b1, 4'd2, 1'b1, 3'd6, 14'd8}, NOE, 1'b1, 1'b1, 3'd2, 32'd95},
    '{2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 14'd4,  32'd0,   32'd0,
      '{1'b1, 4'd1, 1'b0, 3'd0, 14'd4}, NOE, 1'b0, 1'b0, 3'd1, 32'd0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 14'd4,  32'd0,   32'd0,
      '{1'b0, 4'd6, 1'b1, 3'd0, 14'd9}, NOE, 1'b0, 1'b1, 3'd2, 32'd0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 3'd0, 14'd4,  32'd0,   32'd0,
      '{1'b1, 4'd15, 1'b1, 3'd0, 14'd4}, NOE, 1'b0, 1'b1, 3'd3, 32'd0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 3'd0, 14'd4,  32'd500, 32'd400,
      '{1'b1, 4'd1, 1'b1, 3'd0, 14'd4}, NOE, 1'b1, 1'b1, 3'd4, 32'd515}
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1, 2: return "R3";
      3:       return "R5";
      4:       return "R12";
      5:       return "R2";
      6, 7, 8, 9: return "R6";
      10, 11:  return "R7";
      12:      return "R9";
      13, 14:  return "R10";
      15, 16:  return "R8";
      17:      return "R9";
      18:      return "R7";
      default: return "R5";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStrobe = 1'b0;
  logic [1:0] pagePolicy = 2'd0;
  logic reqIsRead = 1'b1;
  logic reqRank = 1'b0;
  logic [2:0] reqBank = 3'd0;
  logic [13:0] reqRow = 14'd0;
  logic [31:0] bankFreeAt = 32'd0;
  logic [31:0] rasDoneAt = 32'd0;
  logic [QD-1:0] rdQValid = '0;
  logic [QD-1:0][0:0] rdQRank = '0;
  logic [QD-1:0][2:0] rdQBank = '0;
  logic [QD-1:0][13:0] rdQRow = '0;
  logic [QD-1:0] wrQValid = '0;
  logic [QD-1:0][0:0] wrQRank = '0;
  logic [QD-1:0][2:0] wrQBank = '0;
  logic [QD-1:0][13:0] wrQRow = '0;
  logic decDone, decPrecharge, decRowHit;
  logic [31:0] decPreDoneAt;
  logic [2:0] decRowCount;
  logic [8:0] decByteCount;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  apd_top u0 (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .pagePolicy(pagePolicy),
    .reqIsRead(reqIsRead), .reqRank(reqRank), .reqBank(reqBank), .reqRow(reqRow),
    .bankFreeAt(bankFreeAt), .rasDoneAt(rasDoneAt),
    .rdQValid(rdQValid), .rdQRank(rdQRank), .rdQBank(rdQBank), .rdQRow(rdQRow),
    .wrQValid(wrQValid), .wrQRank(wrQRank), .wrQBank(wrQBank), .wrQRow(wrQRow),
    .decDone(decDone), .decPrecharge(decPrecharge), .decPreDoneAt(decPreDoneAt),
    .decRowHit(decRowHit), .decRowCount(decRowCount), .decByteCount(decByteCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearQueues();
    rdQValid = '0; rdQRank = '0; rdQBank = '0; rdQRow = '0;
    wrQValid = '0; wrQRank = '0; wrQBank = '0; wrQRow = '0;
  endtask

  task automatic putEntry(input qent_t e, input logic toWr);
    if (e.v) begin
      if (toWr) begin
        wrQValid[e.idx] = 1'b1; wrQRank[e.idx] = e.rk;
        wrQBank[e.idx] = e.bk;  wrQRow[e.idx] = e.row;
      end else begin
        rdQValid[e.idx] = 1'b1; rdQRank[e.idx] = e.rk;
        rdQBank[e.idx] = e.bk;  rdQRow[e.idx] = e.row;
      end
    end else begin
      // invalid entry: fields present, valid bit low
      if (toWr) begin
        wrQRank[e.idx] = e.rk; wrQBank[e.idx] = e.bk; wrQRow[e.idx] = e.row;
      end else begin
        rdQRank[e.idx] = e.rk; rdQBank[e.idx] = e.bk; rdQRow[e.idx] = e.row;
      end
    end
  endtask

  task automatic setReq(input logic [1:0] pol, input logic rd, input logic rk,
                        input logic [2:0] bk, input logic [13:0] row,
                        input logic [31:0] fa, input logic [31:0] ra);
    pagePolicy = pol; reqIsRead = rd; reqRank = rk; reqBank = bk; reqRow = row;
    bankFreeAt = fa; rasDoneAt = ra;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearQueues();
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(decDone == 1'b0, "R13", "done in reset", decDone, 0);
    chk(decPrecharge == 1'b0, "R13", "precharge in reset", decPrecharge, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(decDone == 1'b0, "R1", "done idle", decDone, 0);

    for (int i = 0; i < NV; i++) begin
      clearQueues();
      setReq(VEC[i].pol, VEC[i].rd, VEC[i].rk, VEC[i].bk, VEC[i].row,
             VEC[i].freeAt, VEC[i].rasAt);
      putEntry(VEC[i].e0, VEC[i].toWr);
      putEntry(VEC[i].e1, VEC[i].toWr);
      reqStrobe = 1'b1;
      @(negedge clk);
      reqStrobe = 1'b0;
      chk(decDone == 1'b1, "R1", "done pulse", decDone, 1);
      chk(decPrecharge == VEC[i].expPre, vecTag(i), "precharge", decPrecharge, VEC[i].expPre);
      chk(decRowHit == VEC[i].expHit, "R4", "row hit", decRowHit, VEC[i].expHit);
      chk(decRowCount == VEC[i].expCnt, "R4", "row count", decRowCount, VEC[i].expCnt);
      chk(32'(decByteCount) == 32'(VEC[i].expCnt) * 64, "R4", "byte count",
          decByteCount, 32'(VEC[i].expCnt) * 64);
      chk(decPreDoneAt == VEC[i].expDone, "R11", "precharge done time",
          decPreDoneAt, VEC[i].expDone);
      @(negedge clk);
      chk(decDone == 1'b0, "R1", "done single cycle", decDone, 0);
    end

    // back-to-back strobes on r0 b7 under open policy
    clearQueues();
    setReq(2'd0, 1'b1, 1'b0, 3'd7, 14'd1, 32'd0, 32'd0);
    reqStrobe = 1'b1;
    @(negedge clk);
    chk(decDone == 1'b1, "R1", "first of pair", decDone, 1);
    chk(decRowCount == 3'd1, "R4", "first of pair count", decRowCount, 1);
    @(negedge clk);
    reqStrobe = 1'b0;
    chk(decDone == 1'b1, "R1", "second of pair", decDone, 1);
    chk(decRowHit == 1'b1, "R4", "second of pair hit", decRowHit, 1);
    chk(decRowCount == 3'd2, "R4", "second of pair count", decRowCount, 2);
    @(negedge clk);
    chk(decDone == 1'b0, "R1", "after pair", decDone, 0);

    // R13: reset clears the row table (r0 b3 row 1 was left open)
    rstN = 1'b0;
    @(negedge clk);
    chk(decDone == 1'b0, "R13", "done after reset", decDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    setReq(2'd0, 1'b1, 1'b0, 3'd3, 14'd1, 32'd0, 32'd0);
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    chk(decRowHit == 1'b0, "R13", "row closed by reset", decRowHit, 0);
    chk(decRowCount == 3'd1, "R13", "count restarts after reset", decRowCount, 1);
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule